// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs single clause-22 management transactions, read or write, to an external PHY over a two-wire serial link. A clock pin is driven by the block, and a data pin is shared between both ends through an output, an output enable and an input. Software programs a clock divisor and an enable bit in a configuration word. For a write it loads 16 bits of payload. It then writes one packed control word that holds the PHY address, the register address, one opcode bit and a launch bit.

Completion is seen by polling a ready flag in the same control word. No strobe pair is used. When a read finishes, the 16 bits returned by the PHY sit in a read-data word. The management clock is generated only while a frame is on the wire and stays low otherwise. Each frame has a fixed length of 64 bit periods.

Top module: `mdio_mgmt_top`

## Requirements
- R1: After reset, the configuration word (offset 0x0) reads divisor 29 in bits 5:0 with the enable bit 6 at 0. The control word (offset 0x4) reads 0x0000_0080, which means ready (bit 7) is 1. The read-data word (offset 0xC) reads 0.
- R2: The management clock stays low whenever no frame is in progress. While enable (config bit 6) is 0, a launch request starts no frame and ready stays 1.
- R3: While a frame runs, the management clock toggles every divisor+1 system clocks, which gives a period of 2×(divisor+1) clocks.
- R4: A write frame is launched by a control word with bit 11 (launch) and bit 14 (write) set and bit 15 clear. The PHY address comes from bits 28:24 and the register address from bits 20:16. The frame is 32 ones, 01, 01, the PHY address, the register address, then 10, then the 16 bits from the write-data word (offset 0x8, bits 15:0). Every field is sent MSB first, and the output enable is high for all 64 bits.
- R5: A read frame is launched with bit 15 set and bit 14 clear. It drives 32 ones, 01, 10, the PHY address and the register address. It then releases the line (output enable low) for the last 18 bit periods.
- R6: During a read, the line is sampled on each rising management clock edge of the 16 data bit periods, MSB first. The result appears in bits 15:0 of the read-data word when ready returns to 1.
- R7: A launch request with both opcode bits set, or with neither set, is ignored. No frame starts and ready stays 1.
- R8: Ready reads 0 from the cycle after a launch is accepted until the frame ends. It returns to 1 after the 64th bit period. The launch bit always reads back as 0.
- R9: A launch request written while a frame is in progress is ignored. The running frame completes unchanged and no second frame follows.
- R10: A register read returns its data on bus_rdata one clock after bus_ren. The write-data word reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data, valid one clock after bus_ren |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven to the PHY |
| mdio_oe | output | 1 | Output enable for the serial data pin |
| mdio_i | input | 1 | Serial data received from the pin |

## Verification
The assertions check several properties on every cycle. The clock stays low while idle. The clock holds its level between divider ticks. A frame begins only after a legal launch write. The line is released throughout the turnaround and data part of a read. A frame ends only after its last bit index.

Some behaviour can only be shown by the bench scenarios. These are the exact bit patterns of write and read frames, the measured clock period at several divisors, and the captured read value. They also include the ready behaviour around illegal, disabled and overlapping launch requests, which is observed at the ports.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int DATA_W    = 16;
  localparam int FIELD_W   = 5;
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  // bit index where a read frame stops driving (turnaround start)
  localparam int RD_RELEASE = 46;
  localparam int RD_DATA0   = 48;

  localparam logic [3:0] OFS_CFG = 4'h0;
  localparam logic [3:0] OFS_CTL = 4'h4;
  localparam logic [3:0] OFS_WD  = 4'h8;
  localparam logic [3:0] OFS_RD  = 4'hC;

  localparam int CFG_EN_BIT  = 6;
  localparam int CTL_PHY_LSB = 24;
  localparam int CTL_REG_LSB = 16;
  localparam int CTL_RD_BIT  = 15;
  localparam int CTL_WR_BIT  = 14;
  localparam int CTL_GO_BIT  = 11;
  localparam int CTL_RDY_BIT = 7;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = run && (cnt >= div);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt >= div) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: no toggle between divider ticks
  mdc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && (cnt < div)) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               is_read,
  input  logic [FIELD_W-1:0] phy_addr,
  input  logic [FIELD_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               busy,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rdata
);
  logic [FRAME_LEN-1:0] sr;
  logic [IDX_W-1:0]     idx;
  logic                 rd_mode;
  logic [DATA_W-1:0]    cap;

  assign mdio_o = sr[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      idx     <= '0;
      rd_mode <= 1'b0;
      cap     <= '0;
      busy    <= 1'b0;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else if (start && !busy) begin
      sr      <= {32'hFFFF_FFFF, 2'b01, (is_read ? 2'b10 : 2'b01), phy_addr, reg_addr,
                  (is_read ? 2'b11 : 2'b10), (is_read ? {DATA_W{1'b1}} : wdata)};
      idx     <= '0;
      rd_mode <= is_read;
      busy    <= 1'b1;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (fall) begin
        if (idx == IDX_W'(FRAME_LEN-1)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          rdata   <= cap;
        end else begin
          idx     <= idx + 1'b1;
          sr      <= {sr[FRAME_LEN-2:0], 1'b1};
          mdio_oe <= !(rd_mode && (idx >= IDX_W'(RD_RELEASE-1)));
        end
      end else if (rise && rd_mode && (idx >= IDX_W'(RD_DATA0))) begin
        cap <= {cap[DATA_W-2:0], mdio_i};
      end
    end
  end

  // R5: line released through turnaround and data of a read
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_mode && (idx >= IDX_W'(RD_RELEASE))) |-> !mdio_oe);

  // R8: a frame ends only after its last bit
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(idx) == IDX_W'(FRAME_LEN-1)));
endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int DIV_RST = 29
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wen,
  input  logic        bus_ren,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [DIV_W-1:0]   cfg_div;
  logic               cfg_en;
  logic [FIELD_W-1:0] ctl_phy, ctl_reg;
  logic               ctl_rd, ctl_wr;
  logic [DATA_W-1:0]  wd_q;
  logic [DATA_W-1:0]  rd_q;
  logic               busy, go, rise, fall;
  logic               ctl_wr_hit, op_ok;
  logic [31:0]        cfg_word, ctl_word, rd_mux;
  logic               unused_wbits;

  assign unused_wbits = ^{bus_wdata[31:29], bus_wdata[23:21], bus_wdata[13:12], bus_wdata[10:7]};

  assign ctl_wr_hit = bus_wen && (bus_addr == OFS_CTL);
  assign op_ok      = bus_wdata[CTL_RD_BIT] ^ bus_wdata[CTL_WR_BIT];
  assign go         = ctl_wr_hit && bus_wdata[CTL_GO_BIT] && op_ok && cfg_en && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_div <= DIV_W'(DIV_RST);
      cfg_en  <= 1'b0;
      ctl_phy <= '0;
      ctl_reg <= '0;
      ctl_rd  <= 1'b0;
      ctl_wr  <= 1'b0;
      wd_q    <= '0;
    end else if (bus_wen) begin
      case (bus_addr)
        OFS_CFG: begin
          cfg_div <= bus_wdata[DIV_W-1:0];
          cfg_en  <= bus_wdata[CFG_EN_BIT];
        end
        OFS_CTL: begin
          ctl_phy <= bus_wdata[CTL_PHY_LSB +: FIELD_W];
          ctl_reg <= bus_wdata[CTL_REG_LSB +: FIELD_W];
          ctl_rd  <= bus_wdata[CTL_RD_BIT];
          ctl_wr  <= bus_wdata[CTL_WR_BIT];
        end
        OFS_WD:  wd_q <= bus_wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[DIV_W-1:0]  = cfg_div;
    cfg_word[CFG_EN_BIT] = cfg_en;
    ctl_word = '0;
    ctl_word[CTL_PHY_LSB +: FIELD_W] = ctl_phy;
    ctl_word[CTL_REG_LSB +: FIELD_W] = ctl_reg;
    ctl_word[CTL_RD_BIT]  = ctl_rd;
    ctl_word[CTL_WR_BIT]  = ctl_wr;
    ctl_word[CTL_RDY_BIT] = !busy;
    case (bus_addr)
      OFS_CFG: rd_mux = cfg_word;
      OFS_CTL: rd_mux = ctl_word;
      OFS_WD:  rd_mux = {{(32-DATA_W){1'b0}}, wd_q};
      OFS_RD:  rd_mux = {{(32-DATA_W){1'b0}}, rd_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rd_mux;
  end

  mdio_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk(clk), .rst(rst), .run(busy), .div(cfg_div),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame i_frame (
    .clk(clk), .rst(rst), .start(go), .is_read(bus_wdata[CTL_RD_BIT]),
    .phy_addr(bus_wdata[CTL_PHY_LSB +: FIELD_W]),
    .reg_addr(bus_wdata[CTL_REG_LSB +: FIELD_W]),
    .wdata(wd_q), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rd_q)
  );

  // R2: clock idle low outside a frame
  mdc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R7: a frame begins only from a legal, enabled launch write
  legal_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ctl_wr_hit && bus_wdata[CTL_GO_BIT] && op_ok && cfg_en));
endmodule

// File: tb/test_mdio_mgmt_top.sv
module test_mdio_mgmt_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0, bus_ren = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;
  int          cyc = 0, checks = 0, fails = 0;
  bit          done_flag = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_mgmt_top i_mdio_mgmt_top (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bwr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wen = 1'b0;
  endtask

  task automatic brd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_ren = 1'b1; bus_addr = a;
    @(negedge clk); bus_ren = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(logic [4:0] p, logic [4:0] r, bit rd, bit wr);
    return (32'(p) << 24) | (32'(r) << 16) | (32'(rd) << 15) | (32'(wr) << 14) | 32'h800;
  endfunction

  task automatic capture(logic [15:0] phy_data, output logic [63:0] fo,
                         output logic [63:0] oev, output int half);
    int t0 = 0;
    half = 0;
    for (int i = 0; i < 64; i++) begin
      @(posedge mdc); #1;
      fo[63-i] = mdio_o; oev[63-i] = mdio_oe;
      if (i == 0) t0 = cyc;
      if (i == 1) half = (cyc - t0) / 2;
      if (i >= 47 && i < 63) mdio_i = phy_data[15-(i-47)];
    end
    mdio_i = 1'b1;
  endtask

  task automatic wait_ready(output logic [31:0] d);
    for (int k = 0; k < 200; k++) begin
      brd(4'h4, d);
      if (d[7]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    brd(4'h0, d); chk("R1", "config reset", d, 32'h1D);
    brd(4'h4, d); chk("R1", "control reset", d, 32'h80);
    brd(4'hC, d); chk("R1", "read data reset", d, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    bit seen = 1'b0;
    bwr(4'h4, ctl(5'd3, 5'd1, 1'b0, 1'b1));
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (mdc) seen = 1'b1; end
    chk("R2", "mdc toggled while disabled", 64'(seen), 0);
    brd(4'h4, d); chk("R2", "ready while disabled", 64'(d[7]), 1);
  endtask

  task automatic t_write(int div, logic [4:0] p, logic [4:0] r, logic [15:0] dat);
    logic [31:0] d;
    logic [63:0] fo, oev;
    int half;
    bwr(4'h0, 32'h40 | 32'(div));
    bwr(4'h8, 32'(dat));
    brd(4'h8, d); chk("R10", "write data readback", d, 64'(dat));
    bwr(4'h4, ctl(p, r, 1'b0, 1'b1));
    brd(4'h4, d);
    chk("R8", "ready low in frame", 64'(d[7]), 0);
    chk("R8", "launch bit reads 0", 64'(d[11]), 0);
    capture(16'h0, fo, oev, half);
    chk("R4", "write frame bits", fo, {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, dat});
    chk("R4", "write frame oe", oev, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3", "mdc half period", 64'(half), 64'(div + 1));
    wait_ready(d); chk("R8", "ready after frame", 64'(d[7]), 1);
  endtask

  task automatic t_read(int div, logic [4:0] p, logic [4:0] r, logic [15:0] dat);
    logic [31:0] d;
    logic [63:0] fo, oev;
    int half;
    bwr(4'h0, 32'h40 | 32'(div));
    bwr(4'h4, ctl(p, r, 1'b1, 1'b0));
    capture(dat, fo, oev, half);
    chk("R5", "read frame header", 64'(fo[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, p, r}));
    chk("R5", "read frame oe", oev, 64'hFFFF_FFFF_FFFC_0000);
    chk("R3", "mdc half period", 64'(half), 64'(div + 1));
    wait_ready(d); chk("R8", "ready after read", 64'(d[7]), 1);
    brd(4'hC, d); chk("R6", "read data captured", d, 64'(dat));
  endtask

  task automatic t_bad_op();
    logic [31:0] d;
    bit seen = 1'b0;
    bwr(4'h0, 32'h43);
    bwr(4'h4, ctl(5'd1, 5'd2, 1'b1, 1'b1));
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (mdc) seen = 1'b1; end
    brd(4'h4, d); chk("R7", "both opcodes: ready", 64'(d[7]), 1);
    bwr(4'h4, ctl(5'd1, 5'd2, 1'b0, 1'b0));
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (mdc) seen = 1'b1; end
    brd(4'h4, d); chk("R7", "no opcode: ready", 64'(d[7]), 1);
    chk("R7", "no clock for illegal launch", 64'(seen), 0);
  endtask

  task automatic t_busy_launch();
    logic [31:0] d;
    logic [63:0] fo, oev;
    int half;
    bit seen = 1'b0;
    bwr(4'h0, 32'h43);
    bwr(4'h8, 32'h5A3C);
    bwr(4'h4, ctl(5'd9, 5'd4, 1'b0, 1'b1));
    fork
      capture(16'h0, fo, oev, half);
      begin
        repeat (30) @(negedge clk);
        bwr(4'h8, 32'h0000);
        bwr(4'h4, ctl(5'd22, 5'd7, 1'b1, 1'b0));
        brd(4'h4, d); chk("R9", "still busy after second launch", 64'(d[7]), 0);
      end
    join
    chk("R9", "first frame unchanged", fo, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd4, 2'b10, 16'h5A3C});
    wait_ready(d);
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (mdc) seen = 1'b1; end
    chk("R9", "no second frame", 64'(seen), 0);
    chk("R2", "mdc low when idle", 64'(mdc), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_write(3, 5'h15, 5'h0A, 16'hC3A5);
    t_write(5, 5'h01, 5'h1F, 16'h8001);
    t_read(4, 5'h1E, 5'h01, 16'hB62D);
    t_read(3, 5'h00, 5'h11, 16'h7FFE);
    t_bad_op();
    t_busy_launch();
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule